// File: doc/BRIEF.md
# Sign-Status and Conditional Branch Unit

This unit keeps a three-bit sign status for the most recent value written to the general register file. The status says whether that value, read as a two's complement number, was negative, zero or positive. Each time the register-write strobe is high on a clock edge, the status is reloaded from the value on the write-data bus. When the strobe is low, the status holds its value.

The unit also resolves conditional branches. The branch instruction supplies a three-bit condition mask and a short signed offset. The unit raises the taken flag when any mask bit lines up with the set status bit. It also forms the target address: the incremented program counter plus the sign-extended offset. Both outputs are combinational from the stored status and the current inputs. The decision therefore uses the status as it stood before any register write in the same cycle.

All pins are plain level signals with no valid/ready handshake and no back-pressure. The pipeline around the unit presents one instruction's fields per cycle and samples the results in that same cycle.

Top module: `cond_branch_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the status reads 3'b010 (zero).
- R2: A clock edge with the write strobe high and write-data bit 15 set makes the status 3'b100 (bit 2 = negative) from the next cycle.
- R3: A clock edge with the write strobe high and write data equal to 0 makes the status 3'b010 (bit 1 = zero).
- R4: A clock edge with the write strobe high and nonzero write data that has bit 15 clear makes the status 3'b001 (bit 0 = positive).
- R5: A clock edge with the write strobe low leaves the status unchanged, whatever the write data is.
- R6: Exactly one status bit is set in every cycle.
- R7: The taken flag is high exactly when the condition mask (bit 2 = n, bit 1 = z, bit 0 = p) shares a set bit with the status held before this cycle's write.
- R8: A condition mask of 3'b000 never produces a taken branch.
- R9: The target equals the incremented PC plus the 9-bit offset sign-extended from its bit 8, taken modulo 2^16, whatever the status and mask are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register-file write strobe |
| wr_data | input | 16 | Value being written to the register file |
| cond_mask | input | 3 | Branch condition mask, {n, z, p} |
| next_pc | input | 16 | Incremented program counter |
| offset9 | input | 9 | Signed branch offset |
| status | output | 3 | Sign status, {negative, zero, positive} |
| br_taken | output | 1 | Branch taken |
| br_target | output | 16 | Branch target address |

## Verification
The assertions check on every cycle that the status stays one-hot and that each write loads the class matching the written sign and magnitude. They also check that idle cycles keep the status, that an empty mask never branches, and that the target differs from the PC by the sign-extended offset. The bench's scenarios are needed to show that a write in the same cycle as a branch does not change that branch's decision. They also sweep every mask against every status class, every offset value across PCs that wrap, and the reset value.

// File: rtl/nzp_pkg.sv
package nzp_pkg;
  localparam int unsigned NZP_W = 3;
  localparam int unsigned NEG_BIT = 2;
  localparam int unsigned ZER_BIT = 1;
  localparam int unsigned POS_BIT = 0;

  typedef logic [NZP_W-1:0] nzp_t;

  localparam nzp_t NZP_NEG = nzp_t'(1 << NEG_BIT);
  localparam nzp_t NZP_ZER = nzp_t'(1 << ZER_BIT);
  localparam nzp_t NZP_POS = nzp_t'(1 << POS_BIT);
  localparam nzp_t NZP_RST = NZP_ZER;
endpackage

// File: rtl/nzp_classify.sv
module nzp_classify
  import nzp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  output nzp_t              cls
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (value == '0);
  assign is_neg  = value[DATA_W-1];

  always_comb begin
    if (is_neg)       cls = NZP_NEG;
    else if (is_zero) cls = NZP_ZER;
    else              cls = NZP_POS;
  end
endmodule

// File: rtl/nzp_state_reg.sv
module nzp_state_reg
  import nzp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  nzp_t nzp_d,
  output nzp_t nzp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    nzp_q <= NZP_RST;
    else if (load) nzp_q <= nzp_d;
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import nzp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFFS_W = 9
) (
  input  nzp_t              mask,
  input  nzp_t              nzp_cur,
  input  logic [ADDR_W-1:0] pc_inc,
  input  logic [OFFS_W-1:0] offs,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  localparam int unsigned EXT_W = ADDR_W - OFFS_W;

  logic [NZP_W-1:0]  hit;
  logic [ADDR_W-1:0] offs_ext;

  for (genvar gi = 0; gi < NZP_W; gi++) begin : g_match
    assign hit[gi] = mask[gi] & nzp_cur[gi];
  end

  assign taken    = |hit;
  assign offs_ext = {{EXT_W{offs[OFFS_W-1]}}, offs};
  assign target   = pc_inc + offs_ext;
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import nzp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        cond_mask,
  input  logic [DATA_W-1:0] next_pc,
  input  logic [OFFS_W-1:0] offset9,
  output logic [2:0]        status,
  output logic              br_taken,
  output logic [DATA_W-1:0] br_target
);
  nzp_t wr_cls;
  nzp_t cur_nzp;

  nzp_classify #(.DATA_W(DATA_W)) u_classify (
    .value (wr_data),
    .cls   (wr_cls)
  );

  nzp_state_reg u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_en),
    .nzp_d (wr_cls),
    .nzp_q (cur_nzp)
  );

  branch_resolve #(.ADDR_W(DATA_W), .OFFS_W(OFFS_W)) u_branch (
    .mask    (cond_mask),
    .nzp_cur (cur_nzp),
    .pc_inc  (next_pc),
    .offs    (offset9),
    .taken   (br_taken),
    .target  (br_target)
  );

  assign status = cur_nzp;
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        cond_mask,
  input logic [DATA_W-1:0] next_pc,
  input logic [OFFS_W-1:0] offset9,
  input logic [2:0]        status,
  input logic              br_taken,
  input logic [DATA_W-1:0] br_target
);
  logic [DATA_W-1:0] delta;
  assign delta = br_target - next_pc;

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> status == 3'b010);

  a_r2_load_neg: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[DATA_W-1] |=> status == 3'b100);

  a_r3_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data == '0 |=> status == 3'b010);

  a_r4_load_pos: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[DATA_W-1] && wr_data != '0 |=> status == 3'b001);

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status));

  a_r6_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1);

  a_r7_taken_match: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (cond_mask & status) != 3'b000);

  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    cond_mask == 3'b000 |-> !br_taken);

  a_r9_target_low: assert property (@(posedge clk) disable iff (!rst_n)
    delta[OFFS_W-1:0] == offset9);

  a_r9_target_high: assert property (@(posedge clk) disable iff (!rst_n)
    delta[DATA_W-1:OFFS_W] == (offset9[OFFS_W-1] ? '1 : '0));
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .cond_mask (cond_mask),
  .next_pc   (next_pc),
  .offset9   (offset9),
  .status    (status),
  .br_taken  (br_taken),
  .br_target (br_target)
);

// File: tb/cond_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cond_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  cond_mask = '0;
  logic [15:0] next_pc = '0;
  logic [8:0]  offset9 = '0;
  logic [2:0]  status;
  logic        br_taken;
  logic [15:0] br_target;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cond_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cond_mask(cond_mask), .next_pc(next_pc), .offset9(offset9),
    .status(status), .br_taken(br_taken), .br_target(br_target)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] class_of(input logic [15:0] v);
    if (v[15])        return 3'b100;
    else if (v == 0)  return 3'b010;
    else              return 3'b001;
  endfunction

  // write one value across one edge; inputs change at negedge
  task automatic do_write(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  logic [2:0] exp_st;

  initial begin
    repeat (3) @(negedge clk);
    // R1: status during reset
    check("R1", {29'b0, status}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {29'b0, status}, 32'h2);
    cond_mask = 3'b010; #1;
    check("R7", {31'b0, br_taken}, 32'h1);
    exp_st = 3'b010;

    // R2/R3/R4/R6: sweep write values
    for (int k = 0; k < 65536; k += 251) begin
      logic [15:0] v;
      v = 16'(k);
      do_write(v);
      exp_st = class_of(v);
      check(v[15] ? "R2" : (v == 0 ? "R3" : "R4"), {29'b0, status}, {29'b0, exp_st});
      check("R6", $countones(status), 1);
    end
    foreach (exp_st[i]) ; // no-op
    begin
      logic [15:0] edges [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000};
      foreach (edges[i]) begin
        do_write(edges[i]);
        exp_st = class_of(edges[i]);
        check(edges[i][15] ? "R2" : (edges[i] == 0 ? "R3" : "R4"), {29'b0, status}, {29'b0, exp_st});
      end
    end

    // R5: strobe low, data changes, status holds
    do_write(16'h0005);
    exp_st = 3'b001;
    wr_en = 1'b0;
    wr_data = 16'h8000;
    repeat (3) @(negedge clk);
    check("R5", {29'b0, status}, {29'b0, exp_st});
    wr_data = 16'h0000;
    @(negedge clk);
    check("R5", {29'b0, status}, {29'b0, exp_st});

    // R7/R8: every mask against every status class
    for (int c = 0; c < 3; c++) begin
      logic [15:0] v;
      v = (c == 0) ? 16'hF00D : ((c == 1) ? 16'h0000 : 16'h1234);
      do_write(v);
      exp_st = class_of(v);
      for (int m = 0; m < 8; m++) begin
        cond_mask = 3'(m); #1;
        if (m == 0) check("R8", {31'b0, br_taken}, 32'h0);
        else check("R7", {31'b0, br_taken}, {31'b0, |(3'(m) & exp_st)});
      end
    end

    // R7: same-cycle write must not affect the decision
    do_write(16'h0000);            // status zero
    @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h8001; cond_mask = 3'b010; #1;
    check("R7", {31'b0, br_taken}, 32'h1);
    cond_mask = 3'b100; #1;
    check("R7", {31'b0, br_taken}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R7", {31'b0, br_taken}, 32'h1);

    // R9: all offsets across several PCs, including wrap
    for (int p = 0; p < 4; p++) begin
      logic [15:0] pc;
      pc = (p == 0) ? 16'h3000 : ((p == 1) ? 16'h0000 : ((p == 2) ? 16'hFFFF : 16'hFE10));
      for (int o = 0; o < 512; o++) begin
        int signed so;
        so = (o >= 256) ? o - 512 : o;
        next_pc = pc; offset9 = 9'(o); cond_mask = 3'(o % 8); #1;
        check("R9", {16'b0, br_target}, {16'b0, 16'((int'(pc) + so) & 16'hFFFF)});
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule